// File: doc/BRIEF.md
# Row-Latched Program Memory Write Controller

This block sits on the target side of a serial programming path for a 14-bit flash array. It receives commands that have already been decoded from the serial stream. It keeps a program counter that can only move forward, and it gathers program words in a four-slot write latch. On a begin-programming command it commits the latch to the array. A small register array stands in for the flash cells, and a single configuration word sits above the user space.

Four-word programming is the normal path. The host loads words while stepping the counter through one aligned row. It must not step the counter after the last load, because the row that is written is chosen by the counter bits above the low two. A single-word flag keeps the older one-word flow: only the word at the current counter value is written, and its row neighbours are left as they are. After every commit a busy window of a fixed number of cycles follows, during which load and programming commands are dropped. Read commands return the stored word at the counter.

Top module: `pgm_row_writer`

## Requirements
- R1: After `rst_n` is released, `pc_out` is 0, `busy` is 0 and `rd_valid` is 0, and every array word and the configuration word read as 0x3FFF.
- R2: A command with `cmd_op` = 5 (reset address) sets `pc_out` to 0 on the next cycle.
- R3: A command with `cmd_op` = 0 (increment) adds one to `pc_out`. The counter changes in no other way except through R2 and R4.
- R4: A command with `cmd_op` = 1 (load configuration) sets `pc_out` to 0x2000.
- R5: A command with `cmd_op` = 2 (load data) stores `cmd_data` into the latch slot given by `pc_out[1:0]`. A later load to the same slot replaces the earlier value.
- R6: A command with `cmd_op` = 4 (begin programming), given while `single_word` is 0 and `pc_out` is below 0x2000, writes all four latch slots into the aligned row selected by `pc_out` bits above bit 1. The row is taken modulo the array size. Slots not loaded since the previous commit write 0x3FFF, and the latch returns to 0x3FFF after every commit.
- R7: A begin-programming command given while `single_word` is 1 writes only the word at `pc_out`, using slot `pc_out[1:0]`. The other words of that row keep their contents.
- R8: After an accepted begin-programming command, `busy` is high for exactly BUSY_CYCLES cycles. Load and begin-programming commands that arrive while `busy` is high have no effect.
- R9: A command with `cmd_op` = 3 (read) raises `rd_valid` for one cycle on the next clock. That cycle carries the word stored at the `pc_out` value seen when the command was taken.
- R10: When `pc_out` is 0x2000 or above, a read returns the configuration word, and a begin-programming command writes latch slot `pc_out[1:0]` into the configuration word.
- R11: Commands with `cmd_op` = 6 or 7 change neither the counter nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code (0 increment, 1 load configuration, 2 load data, 3 read, 4 begin programming, 5 reset address) |
| cmd_data | input | 14 | Word carried by a load-data command |
| single_word | input | 1 | 1 selects single-word commits, 0 selects row commits |
| busy | output | 1 | Programming window in progress |
| rd_valid | output | 1 | Read result is present this cycle |
| rd_data | output | 14 | Read result |
| pc_out | output | 14 | Current program counter |

## Verification
The assertions assume that at most one command arrives per cycle and that `single_word` is steady whenever a begin-programming command is taken. The bench drives each command for exactly one clock, changes inputs only at falling edges, and sets the mode flag before the command that uses it. The assertions also assume that the only ways the counter changes are increment, reset address and load configuration. The stimulus therefore verifies earlier rows by issuing reset address and counting up again, never by stepping backwards.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [2:0] {
    OP_INC    = 3'd0,
    OP_LDCFG  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_READ   = 3'd3,
    OP_BEGIN  = 3'd4,
    OP_RESET  = 3'd5
  } pgm_op_e;

  // word position inside the modelled array (array aliases modulo its size)
  function automatic int unsigned word_index(input int unsigned pc, input int unsigned words);
    return pc % words;
  endfunction

  // aligned row number of an address
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned row_words);
    return addr / row_words;
  endfunction

  // slot inside the row
  function automatic int unsigned slot_of(input int unsigned addr, input int unsigned row_words);
    return addr % row_words;
  endfunction

  // configuration space starts at base and runs upward
  function automatic logic in_cfg(input int unsigned pc, input int unsigned base);
    return pc >= base;
  endfunction

endpackage

// File: rtl/pgm_pc_ctr.sv
module pgm_pc_ctr #(
  parameter int PC_W     = 14,
  parameter int CFG_BASE = 'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_clear,
  input  logic            ev_step,
  input  logic            ev_cfg,
  output logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] CFG_PC = PC_W'(CFG_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n)        pc <= '0;
    else if (ev_clear) pc <= '0;
    else if (ev_cfg)   pc <= CFG_PC;
    else if (ev_step)  pc <= pc + 1'b1;
  end

  AST_PC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> pc == '0); // R2

  AST_PC_TO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cfg && !ev_clear) |=> pc == CFG_PC); // R4

  AST_PC_FORWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1 || pc == '0 || pc == CFG_PC)); // R3

endmodule

// File: rtl/pgm_row_latch.sv
module pgm_row_latch #(
  parameter int DATA_W    = 14,
  parameter int ROW_WORDS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ev_load,
  input  logic [$clog2(ROW_WORDS)-1:0]         slot,
  input  logic [DATA_W-1:0]                    din,
  input  logic                                 ev_commit,
  output logic [ROW_WORDS-1:0][DATA_W-1:0]     words
);

  localparam logic [DATA_W-1:0] ERASED = '1;

  for (genvar i = 0; i < ROW_WORDS; i++) begin : g_slot
    logic hit;
    assign hit = ev_load && (int'(slot) == i);

    always_ff @(posedge clk) begin
      if (!rst_n)         words[i] <= ERASED;
      else if (ev_commit) words[i] <= ERASED;
      else if (hit)       words[i] <= din;
    end

    AST_SLOT_ERASED_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ev_commit |=> words[i] == ERASED); // R6
  end

endmodule

// File: rtl/pgm_busy_timer.sv
module pgm_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD_VAL;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R8

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R8

endmodule

// File: rtl/pgm_array.sv
module pgm_array
  import pgm_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int PC_W      = 14,
  parameter int ROW_WORDS = 4,
  parameter int MEM_WORDS = 64,
  parameter int CFG_BASE  = 'h2000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_row,
  input  logic                              we_word,
  input  logic [PC_W-1:0]                   pc,
  input  logic [ROW_WORDS-1:0][DATA_W-1:0]  latch,
  input  logic                              rd_req,
  output logic                              rd_valid,
  output logic [DATA_W-1:0]                 rd_data
);

  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] cfg_word;

  logic              pc_cfg;
  int unsigned       widx;
  int unsigned       wrow;
  int unsigned       wslot;
  logic [DATA_W-1:0] sel_word;
  logic              commit;

  assign pc_cfg   = in_cfg(32'(pc), CFG_BASE);
  assign widx     = word_index(32'(pc), MEM_WORDS);
  assign wrow     = row_of(widx, ROW_WORDS);
  assign wslot    = slot_of(widx, ROW_WORDS);
  assign sel_word = latch[wslot];
  assign commit   = we_row || we_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= ERASED;
      cfg_word <= ERASED;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (commit && pc_cfg) begin
        cfg_word <= sel_word;
      end else if (we_row) begin
        for (int w = 0; w < MEM_WORDS; w++)
          if (row_of(w, ROW_WORDS) == wrow) mem[w] <= latch[slot_of(w, ROW_WORDS)];
      end else if (we_word) begin
        mem[widx] <= sel_word;
      end
      rd_valid <= rd_req;
      if (rd_req) rd_data <= pc_cfg ? cfg_word : mem[widx];
    end
  end

  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(cfg_word)); // R10

endmodule

// File: rtl/pgm_row_writer.sv
module pgm_row_writer
  import pgm_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int PC_W        = 14,
  parameter int ROW_WORDS   = 4,
  parameter int MEM_WORDS   = 64,
  parameter int BUSY_CYCLES = 8,
  parameter int CFG_BASE    = 'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              single_word,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [PC_W-1:0]   pc_out
);

  localparam int SLOT_W = $clog2(ROW_WORDS);

  logic ev_inc, ev_cfg, ev_clear, ev_load, ev_begin, ev_read;
  logic we_row, we_word;
  logic [PC_W-1:0] pc;
  logic [ROW_WORDS-1:0][DATA_W-1:0] latch_q;

  assign ev_inc   = cmd_valid && (cmd_op == OP_INC);
  assign ev_cfg   = cmd_valid && (cmd_op == OP_LDCFG);
  assign ev_clear = cmd_valid && (cmd_op == OP_RESET);
  assign ev_read  = cmd_valid && (cmd_op == OP_READ);
  assign ev_load  = cmd_valid && (cmd_op == OP_LOAD)  && !busy;
  assign ev_begin = cmd_valid && (cmd_op == OP_BEGIN) && !busy;
  assign we_row   = ev_begin && !single_word;
  assign we_word  = ev_begin && single_word;

  pgm_pc_ctr #(.PC_W(PC_W), .CFG_BASE(CFG_BASE)) u_pc (
    .clk(clk), .rst_n(rst_n), .ev_clear(ev_clear), .ev_step(ev_inc),
    .ev_cfg(ev_cfg), .pc(pc)
  );

  pgm_row_latch #(.DATA_W(DATA_W), .ROW_WORDS(ROW_WORDS)) u_latch (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .slot(pc[SLOT_W-1:0]),
    .din(cmd_data), .ev_commit(ev_begin), .words(latch_q)
  );

  pgm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(ev_begin), .busy(busy)
  );

  pgm_array #(.DATA_W(DATA_W), .PC_W(PC_W), .ROW_WORDS(ROW_WORDS),
              .MEM_WORDS(MEM_WORDS), .CFG_BASE(CFG_BASE)) u_array (
    .clk(clk), .rst_n(rst_n), .we_row(we_row), .we_word(we_word), .pc(pc),
    .latch(latch_q), .rd_req(ev_read), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign pc_out = pc;

  AST_LOAD_IGNORED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_op == OP_LOAD) |=> $stable(latch_q)); // R8

  AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == OP_READ)); // R9

  AST_UNUSED_OP_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > 3'd5) |=> $stable(pc_out)); // R11

endmodule

// File: tb/sim_pgm_row_writer.sv
module sim_pgm_row_writer;

  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [13:0] cmd_data = '0;
  logic        single_word = 1'b0;
  logic        busy, rd_valid;
  logic [13:0] rd_data, pc_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgm_row_writer #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .single_word(single_word), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .pc_out(pc_out)
  );

  localparam logic [2:0] C_INC = 3'd0, C_CFG = 3'd1, C_LD = 3'd2, C_RD = 3'd3,
                         C_PGM = 3'd4, C_CLR = 3'd5;

  typedef struct packed {
    logic        sgl;
    logic [2:0]  op;
    logic [13:0] dat;
    logic        chk;
    logic [13:0] exp;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VEC [NV] = '{
    '{1'b0, C_LD,  14'h0101, 1'b0, 14'h0},    // R5 row 0 fill
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_LD,  14'h0102, 1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_LD,  14'h0103, 1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_LD,  14'h0104, 1'b0, 14'h0},
    '{1'b0, C_PGM, 14'h0,    1'b0, 14'h0},    // R6 commit row 0
    '{1'b0, C_CLR, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0101},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0102},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0103},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0104},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h3FFF}, // row 1 untouched
    '{1'b0, C_LD,  14'h0AAA, 1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_LD,  14'h0BBB, 1'b0, 14'h0},
    '{1'b0, C_PGM, 14'h0,    1'b0, 14'h0},    // R6 partial row
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0BBB},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h3FFF},
    '{1'b0, C_CLR, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h0AAA},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h3FFF},
    '{1'b1, C_LD,  14'h1234, 1'b0, 14'h0},    // R7 single word at 5
    '{1'b1, C_PGM, 14'h0,    1'b0, 14'h0},
    '{1'b1, C_RD,  14'h0,    1'b1, 14'h1234},
    '{1'b1, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b1, C_RD,  14'h0,    1'b1, 14'h0BBB},
    '{1'b1, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b1, C_RD,  14'h0,    1'b1, 14'h3FFF},
    '{1'b0, C_CFG, 14'h0,    1'b0, 14'h0},    // R10 configuration word
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h3FFF},
    '{1'b0, C_LD,  14'h2A5A, 1'b0, 14'h0},
    '{1'b0, C_PGM, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h2A5A},
    '{1'b0, C_INC, 14'h0,    1'b0, 14'h0},
    '{1'b0, C_RD,  14'h0,    1'b1, 14'h2A5A}
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [13:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == C_PGM) repeat (BUSY) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check("R1 pc", pc_out, 14'h0);
    check("R1 busy", 14'(busy), 14'h0);
    check("R1 rd_valid", 14'(rd_valid), 14'h0);
    rst_n = 1'b1;
    issue(C_RD, 14'h0);
    check("R1 erased read", rd_data, 14'h3FFF);
    check("R9 rd_valid", 14'(rd_valid), 14'h1);
    @(negedge clk);
    check("R9 one cycle", 14'(rd_valid), 14'h0);

    for (int i = 0; i < NV; i++) begin
      single_word = VEC[i].sgl;
      issue(VEC[i].op, VEC[i].dat);
      if (VEC[i].chk) begin
        check($sformatf("R6/R7/R9/R10 vec %0d valid", i), 14'(rd_valid), 14'h1);
        check($sformatf("R6/R7/R9/R10 vec %0d data", i), rd_data, VEC[i].exp);
      end
    end
    single_word = 1'b0;
    check("R4 cfg pc", pc_out, 14'h2001);

    issue(C_CFG, 14'h0);
    check("R4 load cfg", pc_out, 14'h2000);
    issue(C_CLR, 14'h0);
    check("R2 reset address", pc_out, 14'h0);
    issue(C_INC, 14'h0);
    check("R3 increment", pc_out, 14'h1);
    issue(3'd6, 14'h0);
    check("R11 op6 pc", pc_out, 14'h1);
    check("R11 op6 rd_valid", 14'(rd_valid), 14'h0);
    issue(3'd7, 14'h0);
    check("R11 op7 pc", pc_out, 14'h1);

    issue(C_CLR, 14'h0);
    issue(C_LD, 14'h0055);
    issue(C_LD, 14'h0066);
    issue(C_PGM, 14'h0);
    issue(C_RD, 14'h0);
    check("R5 slot overwrite", rd_data, 14'h0066);

    // R8: busy window length and load ignored inside it
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_PGM;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_LD; cmd_data = 14'h0222;
    b = 0;
    while (busy && b < 20) begin
      b++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    check("R8 busy length", 14'(b), 14'(BUSY));
    issue(C_PGM, 14'h0);
    issue(C_RD, 14'h0);
    check("R8 load ignored while busy", rd_data, 14'h3FFF);

    done = 1'b1;
    summary();
  end

endmodule